// File: doc/BRIEF.md
# SPI FIFO Interrupt Aggregator

This block gathers the interrupt causes of a serial-peripheral controller's data FIFOs into one sticky status register and drives a single level interrupt toward the system. It takes two kinds of cause. Transmit-empty, transmit-underrun, receive-overrun and transmit-half-empty arrive as one-cycle event pulses. Receive-not-empty and receive-full arrive as levels, and these are only folded into the status when the register bus makes an access.

Software reaches three registers through a simple 32-bit request/response bus: a master enable, the sticky status and a per-cause enable. A status bit is cleared by writing back a value that toggles it: the written word is XORed into the status, so writing a 1 inverts that bit. The interrupt line is the registered AND of the master enable with any enabled pending cause.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the master-enable, status and cause-enable registers all read 0 and `irq` is 0.
- R2: Offset 0x1C holds the master enable. Only bit 31 is stored there, and the other bits read 0. Offset 0x20 is the status register. Offset 0x28 is the cause enable, which stores and reads back all 32 bits. A read returns its data on `rsp_rdata` with `rsp_valid` high one clock after the request. The status value returned is the one held before that access's own update.
- R3: An event pulse sets its status bit one clock later, and the bit stays set until software toggles it. The bit positions are transmit empty at 2, transmit underrun at 3, receive overrun at 5 and transmit half empty at 6.
- R4: The receive-not-empty level at bit 8 and the receive-full level at bit 4 are ORed into the status only in a cycle with an access (a read or a write at any offset). While there is no access they leave the status unchanged.
- R5: A write to the status register replaces the status with the status XOR the written word.
- R6: When an event pulse and a status write that would clear the same bit fall in one cycle, the bit ends set.
- R7: `irq` equals master enable AND (status AND cause enable) nonzero, and it changes exactly one clock after the register change that causes it.
- R8: Writes to offsets outside the three registers change nothing, and reads from those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ev_tx_empty | input | 1 | Transmit-empty event pulse |
| ev_tx_underrun | input | 1 | Transmit-underrun event pulse |
| ev_rx_overrun | input | 1 | Receive-overrun event pulse |
| ev_tx_half_empty | input | 1 | Transmit-half-empty event pulse |
| lvl_rx_not_empty | input | 1 | Receive FIFO holds data (level) |
| lvl_rx_full | input | 1 | Receive FIFO is full (level) |
| irq | output | 1 | Level interrupt output |

## Verification
The bench uses the default parameters: an 8-bit offset and the three registers at 0x1C, 0x20 and 0x28. Offsets 0x24 and 0x2C are then free, and the bench uses them to show that stray accesses change no register yet still sample the receive levels. Because the full 32-bit cause enable is kept, the bench can set every enable bit and so watch each cause, and also the toggle of bits that no cause drives.

// File: rtl/spi_irq_agg.sv
module spi_irq_agg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GIE_OFS  = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] EN_OFS   = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half_empty,
  input  logic              lvl_rx_not_empty,
  input  logic              lvl_rx_full,
  output logic              irq
);
  localparam int B_TXE  = 2;
  localparam int B_TXU  = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXO  = 5;
  localparam int B_TXH  = 6;
  localparam int B_RXNE = 8;
  localparam int B_GIE  = 31;

  logic [31:0] stat_q, en_q, ev_vec, lvl_vec, stat_d, rd_mux;
  logic        gie_q;

  wire hit_gie  = req_valid && req_addr == GIE_OFS;
  wire hit_stat = req_valid && req_addr == STAT_OFS;
  wire hit_en   = req_valid && req_addr == EN_OFS;
  wire wr_stat  = hit_stat && req_write;

  always_comb begin
    ev_vec = '0;
    ev_vec[B_TXE] = ev_tx_empty;
    ev_vec[B_TXU] = ev_tx_underrun;
    ev_vec[B_RXO] = ev_rx_overrun;
    ev_vec[B_TXH] = ev_tx_half_empty;
    lvl_vec = '0;
    lvl_vec[B_RXNE] = req_valid && lvl_rx_not_empty;
    lvl_vec[B_RXF]  = req_valid && lvl_rx_full;
  end

  assign stat_d = (wr_stat ? stat_q ^ req_wdata : stat_q) | ev_vec | lvl_vec;

  always_comb begin
    rd_mux = '0;
    if (hit_gie)  rd_mux[B_GIE] = gie_q;
    if (hit_stat) rd_mux = stat_q;
    if (hit_en)   rd_mux = en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      en_q      <= '0;
      gie_q     <= 1'b0;
      irq       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      stat_q    <= stat_d;
      if (hit_en && req_write)  en_q  <= req_wdata;
      if (hit_gie && req_write) gie_q <= req_wdata[B_GIE];
      irq       <= gie_q && |(stat_q & en_q);
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  p_event_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> stat_q[B_RXO]);

  p_level_on_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lvl_rx_full) |=> stat_q[B_RXF]);

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !ev_tx_empty && !ev_tx_underrun && !ev_rx_overrun && !ev_tx_half_empty)
      |=> $stable(stat_q));

  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !ev_tx_empty && !ev_tx_underrun && !ev_rx_overrun && !ev_tx_half_empty
      && !lvl_rx_not_empty && !lvl_rx_full)
      |=> stat_q == ($past(stat_q) ^ $past(req_wdata)));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ev_tx_underrun) |=> stat_q[B_TXU]);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/spi_irq_agg_test.sv
`timescale 1ns/1ps
module spi_irq_agg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [3:0] ev = '0; // {half_empty, underrun, tx_empty, overrun}
  logic lvl_ne = 1'b0, lvl_full = 1'b0;

  int nchk = 0, nerr = 0;
  logic [31:0] m_stat = '0, m_en = '0;
  bit m_gie = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  spi_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ev_tx_empty(ev[1]), .ev_tx_underrun(ev[2]),
    .ev_rx_overrun(ev[0]), .ev_tx_half_empty(ev[3]),
    .lvl_rx_not_empty(lvl_ne), .lvl_rx_full(lvl_full), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ev_bits(input logic [3:0] e);
    logic [31:0] v = '0;
    v[5] = e[0]; v[2] = e[1]; v[3] = e[2]; v[6] = e[3];
    return v;
  endfunction

  function automatic logic [31:0] rd_model(input logic [7:0] a);
    if (a == 8'h1C) return {m_gie, 31'b0};
    if (a == 8'h20) return m_stat;
    if (a == 8'h28) return m_en;
    return '0;
  endfunction

  task automatic bus_op(input bit acc, input bit wr, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] e, input string tag);
    @(negedge clk);
    req_valid = acc; req_write = wr; req_addr = a; req_wdata = d; ev = e;
    if (acc && !wr) begin exp_q.push_back(rd_model(a)); tag_q.push_back(tag); end
    if (acc && wr && a == 8'h20) m_stat = m_stat ^ d;
    m_stat = m_stat | ev_bits(e);
    if (acc) begin
      m_stat[8] = m_stat[8] | lvl_ne;
      m_stat[4] = m_stat[4] | lvl_full;
    end
    if (acc && wr && a == 8'h28) m_en = d;
    if (acc && wr && a == 8'h1C) m_gie = d[31];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag); bus_op(1, 0, a, '0, '0, tag); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag); bus_op(1, 1, a, d, '0, tag); endtask
  task automatic pulse(input logic [3:0] e); bus_op(0, 0, '0, '0, e, "R3"); endtask

  function automatic logic irq_model();
    return m_gie && |(m_stat & m_en);
  endfunction

  // write that changes irq: at the first negedge after the write edge irq is old, one later it is new
  task automatic wr_irq_timed(input logic [7:0] a, input logic [31:0] d, input string tag);
    logic old_irq;
    old_irq = irq_model();
    wr(a, d, tag);
    check({tag, " irq before"}, {31'b0, irq}, {31'b0, old_irq});
    @(negedge clk);
    check({tag, " irq after"}, {31'b0, irq}, {31'b0, irq_model()});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected response", 32'h1, 32'h0);
        else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    rd(8'h1C, "R1 gie reset");
    rd(8'h20, "R1 status reset");
    rd(8'h28, "R1 enable reset");
    wr(8'h28, 32'hFFFF_FFFF, "R2");
    rd(8'h28, "R2 enable readback");
    pulse(4'b0001);
    rd(8'h20, "R3 overrun bit 5");
    check("R7 no irq without global enable", {31'b0, irq}, 32'h0);
    wr_irq_timed(8'h1C, 32'hFFFF_FFFF, "R7 global enable on");
    rd(8'h1C, "R2 gie only bit 31");
    pulse(4'b1110);
    repeat (4) @(negedge clk);
    rd(8'h20, "R3 sticky events");
    lvl_ne = 1'b1; lvl_full = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h20, "R4 levels not sampled without access");
    rd(8'h20, "R4 levels sampled by access");
    lvl_ne = 1'b0; lvl_full = 1'b0;
    rd(8'h20, "R4 level bits sticky");
    wr_irq_timed(8'h20, 32'h0000_017C, "R5 toggle clears all, R7 irq falls");
    rd(8'h20, "R5 cleared");
    wr(8'h20, 32'h0000_0003, "R5");
    rd(8'h20, "R5 toggle sets");
    wr(8'h20, 32'h0000_0001, "R5");
    rd(8'h20, "R5 toggle clears one");
    pulse(4'b0001);
    bus_op(1, 1, 8'h20, 32'h0000_0020, 4'b0001, "R6");
    rd(8'h20, "R6 event beats toggle");
    bus_op(1, 1, 8'h20, 32'h0000_0002, 4'b0100, "R6");
    rd(8'h20, "R6 underrun set with other toggle");
    wr(8'h24, 32'hFFFF_FFFF, "R8");
    wr(8'h2C, 32'h0000_0000, "R8");
    rd(8'h24, "R8 unmapped read zero");
    rd(8'h20, "R8 status untouched");
    rd(8'h28, "R8 enable untouched");
    rd(8'h1C, "R8 gie untouched");
    wr_irq_timed(8'h28, 32'h0000_0000, "R7 enable mask off");
    wr_irq_timed(8'h28, 32'h0000_0008, "R7 enable underrun only");
    wr_irq_timed(8'h1C, 32'h7FFF_FFFF, "R7 gie bit 31 clear");
    lvl_full = 1'b1;
    wr(8'h24, 32'h0, "R4");
    lvl_full = 1'b0;
    rd(8'h20, "R4 write access samples level");
    repeat (3) @(negedge clk);
    check("R2 all responses seen", exp_q.size(), 32'h0);
    check("R7 final irq", {31'b0, irq}, {31'b0, irq_model()});
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule